// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers every interrupt cause of a small 8-bit processor and decides which one the core services next. Twelve internal event pulses and two edge-detected external pins each set a latched request flag. Each flag has its own enable flag. The core's interrupt-disable flag gates all of these maskable sources. Two causes ignore that gate: reset, and a software-break request.

When a source wins, the controller does three things in one clock cycle. It raises a one-cycle accept strobe. It presents the 16-bit address of the low byte of that source's vector pair. It asks the core to set its disable flag. In the same cycle it clears the winner's request flag. Software reaches the request, enable and polarity flags through a small byte-wide register port. Stacking of the program counter and status register is left to the core.

Top module: `prio_vec_intc`

## Requirements
- R1: A maskable source is accepted only if its request flag is 1, its enable flag is 1 and `iflag_i` was 0 in the cycle before the accept strobe. A pending request with a 0 enable flag is never accepted, and the request stays readable as 1.
- R2: On accept, `take_o` and `set_iflag_o` are both high for that one cycle. The winner's request flag reads back 0 afterwards.
- R3: Writing a byte to a request register clears each flag whose written bit is 0. A written bit of 1 leaves that flag unchanged, so software can never set a request.
- R4: The register map has five byte-wide registers:
  - address 0: request flags for slots 0–7, slot n in bit n;
  - address 1: request flags for slots 8–13, in bits 0–5;
  - address 2: enable flags for slots 0–7;
  - address 3: enable flags for slots 8–13;
  - address 4: the two polarity bits, bit 0 for pin A and bit 1 for pin B.
  
  Enable and polarity bits read back exactly what was written. Unused bits read 0.
- R5: Reset clears every request, enable and polarity flag. The first accept after reset is released is always the reset source, with vector 16'hFFFE, and it is taken regardless of `iflag_i`.
- R6: Maskable slot k has priority k+2 and vector 16'hFFFC − 2k. When several slots are acceptable, the lowest slot number wins.
  - Pin A feeds slot 1 and pin B feeds slot 12.
  - The internal events fill the other slots in ascending order: evt_i bit j goes to slot j for j=0, slot j+1 for j=1..10, and slot 13 for j=11.
- R7: A pulse on `brk_i` is held until it is taken. It has the lowest priority and vector 16'hFFDE. It is taken even while `iflag_i` is 1, but never while a maskable source is acceptable.
- R8: Each pin passes through a two-stage synchronizer. A polarity bit of 0 selects LOW-to-HIGH detection and 1 selects HIGH-to-LOW. The opposite edge sets nothing. A detected edge sets the request flag within five cycles.
- R9: `vector_o` changes only in a cycle where `take_o` is high. `take_o` is never high in two consecutive cycles.
- R10: If an event sets a request flag in the same cycle that software clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin_i | input | 2 | External pins; bit 0 is pin A (slot 1), bit 1 is pin B (slot 12) |
| evt_i | input | 12 | Internal one-cycle event pulses |
| brk_i | input | 1 | Break-instruction request pulse |
| iflag_i | input | 1 | Core's interrupt-disable flag |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| take_o | output | 1 | One-cycle accept strobe |
| vector_o | output | 16 | Low-byte address of the winning vector pair |
| set_iflag_o | output | 1 | Command to set the core's disable flag |

## Verification
The assertions assume the core behaves like a real processor. After each accept it raises `iflag_i` before the next edge of the accept pair. It keeps the polarity bits steady while a pin is changing.

The stimulus models exactly that behaviour. A monitor raises the disable flag at the falling edge after every strobe. Polarity is written only while the pin is idle. Event pulses last exactly one cycle and are driven between rising edges.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADR_REQ_LO = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADR_REQ_HI = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADR_EN_LO  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADR_EN_HI  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADR_POL    = 3'd4;

  localparam logic [15:0] VEC_RESET = 16'hFFFE;
  localparam logic [15:0] VEC_BREAK = 16'hFFDE;

  // Vector of maskable slot k (priority k+2): one byte pair per level below reset.
  function automatic logic [15:0] slot_vector(input int unsigned k);
    return 16'hFFFC - 16'(2 * k);
  endfunction

  // Internal event bit feeding slot k, skipping the two pin slots.
  function automatic int unsigned evt_of_slot(input int unsigned k,
                                              input int unsigned pa,
                                              input int unsigned pb);
    return k - ((k > pa) ? 1 : 0) - ((k > pb) ? 1 : 0);
  endfunction
endpackage

// File: rtl/pvic_edge.sv
module pvic_edge #(
  parameter int unsigned PIN_N  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] pin_i,
  input  logic [PIN_N-1:0] pol_i,
  output logic [PIN_N-1:0] edge_o
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    logic [STAGES:0] shf_q;
    logic            now_w, old_w;

    always_ff @(posedge clk) begin
      if (!rst_n) shf_q <= '0;
      else        shf_q <= {shf_q[STAGES-1:0], pin_i[i]};
    end

    assign now_w     = shf_q[STAGES-1];
    assign old_w     = shf_q[STAGES];
    assign edge_o[i] = pol_i[i] ? (old_w & ~now_w) : (now_w & ~old_w);

    p_edge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o[i] |=> (!edge_o[i] || (pol_i[i] != $past(pol_i[i]))));
  end
endmodule

// File: rtl/pvic_regs.sv
module pvic_regs
  import pvic_pkg::*;
#(
  parameter int unsigned SLOT_N = 14,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PIN_N  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOT_N-1:0]     set_i,
  input  logic [SLOT_N-1:0]     clr_i,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [SLOT_N-1:0]     req_o,
  output logic [SLOT_N-1:0]     en_o,
  output logic [PIN_N-1:0]      pol_o
);
  localparam int unsigned HI_W = SLOT_N - DATA_W;

  logic [SLOT_N-1:0] req_q, req_n, en_q, en_n, keep_w;
  logic [PIN_N-1:0]  pol_q, pol_n;

  always_comb begin
    keep_w = '1;
    en_n   = en_q;
    pol_n  = pol_q;
    if (we_i) begin
      case (addr_i)
        ADR_REQ_LO: keep_w[DATA_W-1:0]      = wdata_i;
        ADR_REQ_HI: keep_w[SLOT_N-1:DATA_W] = wdata_i[HI_W-1:0];
        ADR_EN_LO:  en_n[DATA_W-1:0]        = wdata_i;
        ADR_EN_HI:  en_n[SLOT_N-1:DATA_W]   = wdata_i[HI_W-1:0];
        ADR_POL:    pol_n                   = wdata_i[PIN_N-1:0];
        default: ;
      endcase
    end
    req_n = (req_q & keep_w & ~clr_i) | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      en_q  <= '0;
      pol_q <= '0;
    end else begin
      req_q <= req_n;
      en_q  <= en_n;
      pol_q <= pol_n;
    end
  end

  always_comb begin
    case (addr_i)
      ADR_REQ_LO: rdata_o = req_q[DATA_W-1:0];
      ADR_REQ_HI: rdata_o = {{(DATA_W-HI_W){1'b0}}, req_q[SLOT_N-1:DATA_W]};
      ADR_EN_LO:  rdata_o = en_q[DATA_W-1:0];
      ADR_EN_HI:  rdata_o = {{(DATA_W-HI_W){1'b0}}, en_q[SLOT_N-1:DATA_W]};
      ADR_POL:    rdata_o = {{(DATA_W-PIN_N){1'b0}}, pol_q};
      default:    rdata_o = '0;
    endcase
  end

  assign req_o = req_q;
  assign en_o  = en_q;
  assign pol_o = pol_q;

  p_take_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((req_q & $past(clr_i & ~set_i)) == '0));

  p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_q & ~$past(req_q) & ~$past(set_i)) == '0));

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((req_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int unsigned SLOT_N = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_N-1:0] pend_i,
  input  logic              iflag_i,
  input  logic              brk_i,
  output logic [SLOT_N-1:0] clr_o,
  output logic              take_o,
  output logic [15:0]       vec_o
);
  logic              boot_q, brk_q, take_q;
  logic [15:0]       vec_q;
  logic [SLOT_N-1:0] live_w;
  logic              win_vld, can_go, brk_win, boot_win;
  logic [15:0]       win_vec;
  int unsigned       pick;

  assign live_w = iflag_i ? '0 : pend_i;
  assign can_go = !take_q;

  always_comb begin
    pick = 0;
    for (int k = SLOT_N - 1; k >= 0; k--) begin
      if (live_w[k]) pick = k;
    end
  end

  always_comb begin
    win_vld  = 1'b0;
    win_vec  = vec_q;
    clr_o    = '0;
    brk_win  = 1'b0;
    boot_win = 1'b0;
    if (boot_q) begin
      win_vld  = 1'b1;
      win_vec  = VEC_RESET;
      boot_win = can_go;
    end else if (|live_w) begin
      win_vld     = 1'b1;
      win_vec     = slot_vector(pick);
      clr_o[pick] = can_go;
    end else if (brk_q) begin
      win_vld = 1'b1;
      win_vec = VEC_BREAK;
      brk_win = can_go;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q <= 1'b1;
      brk_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= win_vld && can_go;
      if (win_vld && can_go) vec_q <= win_vec;
      if (boot_win) boot_q <= 1'b0;
      brk_q <= brk_i | (brk_q & ~brk_win);
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;

  p_masked_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (vec_o != VEC_RESET) && (vec_o != VEC_BREAK)) |-> $past(!iflag_i));

  p_brk_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (vec_o == VEC_BREAK)) |-> $past(iflag_i || (pend_i == '0)));

  p_take_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(vec_o));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvic_pkg::*;
#(
  parameter int unsigned SLOT_N  = 14,
  parameter int unsigned PIN_N   = 2,
  parameter int unsigned PIN_A   = 1,
  parameter int unsigned PIN_B   = 12,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned EVT_N  = SLOT_N - PIN_N
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIN_N-1:0]      ext_pin_i,
  input  logic [EVT_N-1:0]      evt_i,
  input  logic                  brk_i,
  input  logic                  iflag_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  take_o,
  output logic [15:0]           vector_o,
  output logic                  set_iflag_o
);
  logic [PIN_N-1:0]  pol_w, edge_w;
  logic [SLOT_N-1:0] hw_set_w, acc_clr_w, req_w, en_w;

  pvic_edge #(.PIN_N(PIN_N), .STAGES(SYNC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .pol_i(pol_w), .edge_o(edge_w)
  );

  for (genvar k = 0; k < SLOT_N; k++) begin : g_src
    if (k == PIN_A) begin : g_pa
      assign hw_set_w[k] = edge_w[0];
    end else if (k == PIN_B) begin : g_pb
      assign hw_set_w[k] = edge_w[1];
    end else begin : g_ev
      localparam int unsigned J = evt_of_slot(k, PIN_A, PIN_B);
      assign hw_set_w[k] = evt_i[J];
    end
  end

  pvic_regs #(.SLOT_N(SLOT_N), .DATA_W(DATA_W), .PIN_N(PIN_N)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(hw_set_w), .clr_i(acc_clr_w),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .req_o(req_w), .en_o(en_w), .pol_o(pol_w)
  );

  pvic_arb #(.SLOT_N(SLOT_N)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(req_w & en_w), .iflag_i(iflag_i),
    .brk_i(brk_i), .clr_o(acc_clr_w), .take_o(take_o), .vec_o(vector_o)
  );

  assign set_iflag_o = take_o;
endmodule

// File: tb/prio_vec_intc_tb.sv
module prio_vec_intc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin = '0;
  logic [11:0] evt = '0;
  logic        brk = 1'b0;
  logic        iflag = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        take_o, set_iflag_o;
  logic [15:0] vector_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] exp_q[$];
  logic prev_take = 1'b0;

  always #4 clk = ~clk;

  prio_vec_intc dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .evt_i(evt), .brk_i(brk),
    .iflag_i(iflag), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .take_o(take_o), .vector_o(vector_o),
    .set_iflag_o(set_iflag_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected vector of maskable slot k, computed independently.
  function automatic logic [15:0] vec_exp(input int k);
    return 16'(32'h10000 - 2 * (k + 2));
  endfunction

  // Monitor: pops the scoreboard on every strobe, then models the core raising I.
  always @(negedge clk) begin
    if (rst_n && take_o) begin
      chk("R9 no back-to-back accept", {31'd0, prev_take}, 32'd0);
      chk("R2 set-iflag with accept", {31'd0, set_iflag_o}, 32'd1);
      if (exp_q.size() == 0) begin
        chk("R1 unexpected accept", {16'd0, vector_o}, 32'hFFFFFFFF);
      end else begin
        chk("R6 vector order", {16'd0, vector_o}, {16'd0, exp_q.pop_front()});
      end
      iflag = 1'b1;
    end
    prev_take = take_o;
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; #1;
    chk(tag, {24'd0, rdata}, {24'd0, e});
  endtask

  task automatic pulse_evt(input logic [11:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    idle(6);
    chk(tag, exp_q.size(), 0);
  endtask

  task automatic rti();
    @(negedge clk); iflag = 1'b0;
    idle(6);
  endtask

  initial begin
    #(8 * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_q.push_back(16'hFFFE);                 // R5 boot vector
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    drained("R5 reset accept taken");
    for (int a = 0; a < 5; a++) rd(3'(a), 8'h00, "R5 reset register state");

    // R4 enable read-back
    wr(3'd2, 8'h20); rd(3'd2, 8'h20, "R4 enable lo readback");
    wr(3'd3, 8'h22); rd(3'd3, 8'h22, "R4 enable hi readback");

    // R1 masked by iflag, then R2 accept and clear (slot 5 = evt bit 4)
    pulse_evt(12'h010); idle(3);
    rd(3'd0, 8'h20, "R1 held by disable flag");
    exp_q.push_back(vec_exp(5));
    rti();
    chk("R2 accept drained", exp_q.size(), 0);
    rd(3'd0, 8'h00, "R2 request cleared on accept");

    // R1 enable gating (slot 0 disabled), R3 write semantics
    pulse_evt(12'h001); idle(4);
    rd(3'd0, 8'h01, "R1 disabled source stays pending");
    wr(3'd0, 8'hFF); rd(3'd0, 8'h01, "R3 write one no effect");
    wr(3'd0, 8'hFE); rd(3'd0, 8'h00, "R3 write zero clears");
    wr(3'd0, 8'hFF); rd(3'd0, 8'h00, "R3 write one cannot set");

    // R6 priority: slots 3, 9, 13 (evt bits 2, 8, 11)
    @(negedge clk); iflag = 1'b1;
    wr(3'd2, 8'h28);
    pulse_evt(12'h904);
    exp_q.push_back(vec_exp(3));
    exp_q.push_back(vec_exp(9));
    exp_q.push_back(vec_exp(13));
    rti(); rti(); rti();
    drained("R6 three accepts in priority order");

    // R7 break while masked
    @(negedge clk); brk = 1'b1; exp_q.push_back(16'hFFDE);
    @(negedge clk); brk = 1'b0;
    drained("R7 break taken with disable set");

    // R7 break loses to a same-cycle maskable request
    exp_q.push_back(vec_exp(5));
    exp_q.push_back(16'hFFDE);
    @(negedge clk); iflag = 1'b0; evt = 12'h010; brk = 1'b1;
    @(negedge clk); evt = '0; brk = 1'b0;
    drained("R7 break after maskable");

    // R8 pin A (slot 1 -> reg0 bit1), rising with polarity 0
    @(negedge clk); ext_pin[0] = 1'b1; idle(5);
    rd(3'd0, 8'h02, "R8 rising edge detected");
    wr(3'd0, 8'hFD);
    @(negedge clk); ext_pin[0] = 1'b0; idle(5);
    rd(3'd0, 8'h00, "R8 falling ignored at polarity 0");
    wr(3'd4, 8'h01); rd(3'd4, 8'h01, "R4 polarity readback");
    @(negedge clk); ext_pin[0] = 1'b1; idle(5);
    rd(3'd0, 8'h00, "R8 rising ignored at polarity 1");
    @(negedge clk); ext_pin[0] = 1'b0; idle(5);
    rd(3'd0, 8'h02, "R8 falling edge detected");
    wr(3'd0, 8'hFD);
    // pin B (slot 12 -> reg1 bit4)
    @(negedge clk); ext_pin[1] = 1'b1; idle(5);
    rd(3'd1, 8'h10, "R8 pin B rising edge");
    wr(3'd1, 8'hEF); rd(3'd1, 8'h00, "R3 clear pin B request");

    // R10 set and clear in the same cycle
    @(negedge clk); evt = 12'h001; we = 1'b1; addr = 3'd0; wdata = 8'h00;
    @(negedge clk); evt = '0; we = 1'b0;
    rd(3'd0, 8'h01, "R10 hardware set wins");
    wr(3'd0, 8'h00);

    // R9 vector holds while idle
    idle(4); #1;
    chk("R9 vector held after last accept", {16'd0, vector_o}, 32'h0000FFDE);
    drained("R1 no stray accepts");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule